// File: doc/BRIEF.md
# Upstream Port Override and Status Register

This block is one 8-bit register that software reaches over a simple CPU register bus. It sits between the serial interface engine of a full-speed USB device and the D+/D- pad drivers. A three-bit control field either gives the pads to the engine or forces the two lines to fixed levels. Those fixed levels include driving a line low or high, signalling SE0, and releasing one or both lines to high impedance.

The same register also reports the live levels of D+ and D- through a two-flop synchronizer. It holds a sticky bus-activity flag that only the engine can set and that firmware clears by writing zero. Two endpoint-configuration bits are kept as plain storage and are brought out to the endpoint logic. A read returns the contents in the same cycle as the read strobe. A write takes effect at the next clock edge.

Register layout (address `REG_ADDR`, default 0x1F): bit 7 endpoint size, bit 6 endpoint mode, bit 5 synchronized D+ level, bit 4 synchronized D- level, bit 3 bus activity, bits 2..0 override code.

Top module: `usb_port_ctrl_reg`

## Requirements
- R1: After reset every register bit reads 0, both endpoint outputs are 0, and the pads follow the engine.
- R2: With override code 000, each pad's output value and output enable equal the engine's value and enable for that line.
- R3: Codes 001 to 100 drive both lines with their enables set. 001 gives D+ high and D- low. 010 gives D+ low and D- high. 011 and 100 give both lines low.
- R4: Code 101 floats D+ (enable 0) and drives D- low. Code 110 drives D+ low and floats D-. Code 111 floats both lines.
- R5: Bits 7, 6 and 2..0 read back the last value written to `REG_ADDR`. Bits 7 and 6 appear on `ep_size` and `ep_mode`. A write to any other address changes nothing.
- R6: Bits 5 and 4 show the D+ and D- pin levels (1 = high) two clock edges after a pin changes. Writes to these bits have no effect.
- R7: An engine activity pulse sets bit 3 at the next edge, and the bit stays set until it is cleared.
- R8: Writing 0 to bit 3 clears it. Writing 1 to bit 3 leaves it unchanged.
- R9: If an activity pulse and a clearing write occur in the same cycle, bit 3 ends up set.
- R10: Read data is valid in the same cycle as a read strobe to `REG_ADDR`. At any other time it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| sie_dp_out | input | 1 | Engine D+ drive value |
| sie_dp_oe | input | 1 | Engine D+ drive enable |
| sie_dm_out | input | 1 | Engine D- drive value |
| sie_dm_oe | input | 1 | Engine D- drive enable |
| sie_activity | input | 1 | Engine pulse marking a non-idle bus event |
| pad_dp_in | input | 1 | D+ pin level |
| pad_dm_in | input | 1 | D- pin level |
| pad_dp_out | output | 1 | D+ pad drive value |
| pad_dp_oe | output | 1 | D+ pad drive enable |
| pad_dm_out | output | 1 | D- pad drive value |
| pad_dm_oe | output | 1 | D- pad drive enable |
| ep_size | output | 1 | Endpoint size bit |
| ep_mode | output | 1 | Endpoint mode bit |

## Verification
The engine's activity pulse and a firmware write that clears bit 3 can fall in the same clock cycle. The bench provokes this by raising `sie_activity` in the same cycle as a write of 0x00. It then reads the register back and expects bit 3 to be set. The same pair of events is also checked cycle by cycle by a property that expects the flag set after any cycle that carried an activity pulse.

// File: rtl/usb_port_ctrl_reg.sv
module usb_port_ctrl_reg #(
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h1F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              sie_dp_out,
  input  logic              sie_dp_oe,
  input  logic              sie_dm_out,
  input  logic              sie_dm_oe,
  input  logic              sie_activity,
  input  logic              pad_dp_in,
  input  logic              pad_dm_in,
  output logic              pad_dp_out,
  output logic              pad_dp_oe,
  output logic              pad_dm_out,
  output logic              pad_dm_oe,
  output logic              ep_size,
  output logic              ep_mode
);

  localparam int SYNC_N = 2;

  logic              hit;
  logic              wr_hit;
  logic [2:0]        ctrl;
  logic              act;
  logic              ep_size_q, ep_mode_q;
  logic [SYNC_N-1:0] dp_sync, dm_sync;
  logic [7:0]        reg_val;

  assign hit    = (bus_addr == REG_ADDR);
  assign wr_hit = bus_wr && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      ep_size_q <= 1'b0;
      ep_mode_q <= 1'b0;
    end else if (wr_hit) begin
      ctrl      <= bus_wdata[2:0];
      ep_size_q <= bus_wdata[7];
      ep_mode_q <= bus_wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      act <= 1'b0;
    else if (sie_activity)
      act <= 1'b1;
    else if (wr_hit && !bus_wdata[3])
      act <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dp_sync <= '0;
      dm_sync <= '0;
    end else begin
      dp_sync <= {dp_sync[SYNC_N-2:0], pad_dp_in};
      dm_sync <= {dm_sync[SYNC_N-2:0], pad_dm_in};
    end
  end

  assign reg_val   = {ep_size_q, ep_mode_q, dp_sync[SYNC_N-1], dm_sync[SYNC_N-1], act, ctrl};
  assign bus_rdata = (bus_rd && hit) ? reg_val : 8'h00;
  assign ep_size   = ep_size_q;
  assign ep_mode   = ep_mode_q;

  always_comb begin
    pad_dp_out = 1'b0;
    pad_dm_out = 1'b0;
    pad_dp_oe  = 1'b1;
    pad_dm_oe  = 1'b1;
    case (ctrl)
      3'b000: begin
        pad_dp_out = sie_dp_out;
        pad_dp_oe  = sie_dp_oe;
        pad_dm_out = sie_dm_out;
        pad_dm_oe  = sie_dm_oe;
      end
      3'b001: pad_dp_out = 1'b1;
      3'b010: pad_dm_out = 1'b1;
      3'b101: pad_dp_oe  = 1'b0;
      3'b110: pad_dm_oe  = 1'b0;
      3'b111: begin
        pad_dp_oe = 1'b0;
        pad_dm_oe = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

module usb_port_ctrl_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_hit,
  input logic [7:0] bus_wdata,
  input logic       sie_activity,
  input logic [2:0] ctrl,
  input logic       act,
  input logic       ep_size,
  input logic       ep_mode,
  input logic       sie_dp_out,
  input logic       sie_dp_oe,
  input logic       pad_dp_out,
  input logic       pad_dp_oe,
  input logic       pad_dm_oe
);

  AST_ACT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    sie_activity |=> act);  // R7 R9

  AST_ACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !(wr_hit && !bus_wdata[3])) |=> act);  // R7

  AST_ACT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !bus_wdata[3] && !sie_activity) |=> !act);  // R8

  AST_EP_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (ep_size == $past(bus_wdata[7]) && ep_mode == $past(bus_wdata[6])));  // R5

  AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 3'b000) |-> (pad_dp_out == sie_dp_out && pad_dp_oe == sie_dp_oe));  // R2

  AST_FLOAT_DP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 3'b101 || ctrl == 3'b111) |-> !pad_dp_oe);  // R4

  AST_FLOAT_DM: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl == 3'b110 || ctrl == 3'b111) |-> !pad_dm_oe);  // R4

endmodule

bind usb_port_ctrl_reg usb_port_ctrl_reg_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_hit       (wr_hit),
  .bus_wdata    (bus_wdata),
  .sie_activity (sie_activity),
  .ctrl         (ctrl),
  .act          (act),
  .ep_size      (ep_size),
  .ep_mode      (ep_mode),
  .sie_dp_out   (sie_dp_out),
  .sie_dp_oe    (sie_dp_oe),
  .pad_dp_out   (pad_dp_out),
  .pad_dp_oe    (pad_dp_oe),
  .pad_dm_oe    (pad_dm_oe)
);

// File: tb/tb_usb_port_ctrl_reg.sv
module tb_usb_port_ctrl_reg;

  localparam logic [7:0] A = 8'h1F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic sie_dp_out = 0, sie_dp_oe = 0, sie_dm_out = 0, sie_dm_oe = 0, sie_activity = 0;
  logic pad_dp_in = 0, pad_dm_in = 0;
  logic pad_dp_out, pad_dp_oe, pad_dm_out, pad_dm_oe, ep_size, ep_mode;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  usb_port_ctrl_reg dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] addr, input logic [7:0] d, input logic pulse);
    @(negedge clk);
    bus_addr = addr; bus_wdata = d; bus_wr = 1'b1; sie_activity = pulse;
    @(negedge clk);
    bus_wr = 1'b0; sie_activity = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk);
    bus_addr = A; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
    #1;
  endtask

  function automatic logic [3:0] pads(input logic [2:0] c);
    case (c)
      3'd1: return 4'b1_1_0_1;
      3'd2: return 4'b0_1_1_1;
      3'd3, 3'd4: return 4'b0_1_0_1;
      3'd5: return 4'b0_0_0_1;
      3'd6: return 4'b0_1_0_0;
      3'd7: return 4'b0_0_0_0;
      default: return 4'bxxxx;
    endcase
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    rd(d);
    check("R1 reg", d, 8'h00);
    check("R1 ep", {6'd0, ep_size, ep_mode}, 8'h00);
    sie_dp_out = 1; sie_dp_oe = 1; #1;
    check("R1 pads", {4'd0, pad_dp_out, pad_dp_oe, pad_dm_out, pad_dm_oe}, 8'b0000_1100);
    bus_rd = 1'b0; #1;
    check("R10 idle", bus_rdata, 8'h00);
  endtask

  task automatic t_pass();
    for (int i = 0; i < 16; i++) begin
      {sie_dp_out, sie_dp_oe, sie_dm_out, sie_dm_oe} = 4'(i);
      #1 check("R2 pass", {4'd0, pad_dp_out, pad_dp_oe, pad_dm_out, pad_dm_oe}, 8'(i));
    end
  endtask

  task automatic t_force();
    {sie_dp_out, sie_dp_oe, sie_dm_out, sie_dm_oe} = 4'b1010;
    for (int c = 1; c < 8; c++) begin
      wr(A, 8'(c), 1'b0);
      #1 check(c < 5 ? "R3 force" : "R4 float",
               {4'd0, pad_dp_out, pad_dp_oe, pad_dm_out, pad_dm_oe}, {4'd0, pads(3'(c))});
    end
    wr(A, 8'h00, 1'b0);
  endtask

  task automatic t_store();
    logic [7:0] d;
    wr(A, 8'hC5, 1'b0);
    rd(d);
    check("R5 store", d, 8'hC5);
    check("R5 ep", {6'd0, ep_size, ep_mode}, 8'h03);
    wr(8'h1E, 8'h00, 1'b0);
    rd(d);
    check("R5 other addr", d, 8'hC5);
    wr(A, 8'h42, 1'b0);
    rd(d);
    check("R5 store2", d, 8'h42);
    wr(A, 8'h00, 1'b0);
  endtask

  task automatic t_ro();
    logic [7:0] d;
    wr(A, 8'h30, 1'b0);
    rd(d);
    check("R6 ro write", d, 8'h00);
    @(negedge clk);
    pad_dp_in = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b1; #1 d = bus_rdata; bus_rd = 1'b0;
    check("R6 one edge", d, 8'h00);
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b1; #1 d = bus_rdata; bus_rd = 1'b0;
    check("R6 dp two edges", d, 8'h20);
    pad_dp_in = 1'b0; pad_dm_in = 1'b1;
    repeat (3) @(posedge clk);
    rd(d);
    check("R6 dm", d, 8'h10);
    pad_dm_in = 1'b0;
    repeat (3) @(posedge clk);
  endtask

  task automatic t_act();
    logic [7:0] d;
    @(negedge clk); sie_activity = 1'b1;
    @(negedge clk); sie_activity = 1'b0;
    repeat (4) @(posedge clk);
    rd(d);
    check("R7 sticky", d, 8'h08);
    wr(A, 8'h08, 1'b0);
    rd(d);
    check("R8 write1 keeps", d, 8'h08);
    wr(A, 8'h00, 1'b0);
    rd(d);
    check("R8 write0 clears", d, 8'h00);
    wr(A, 8'h00, 1'b1);
    rd(d);
    check("R9 set wins", d, 8'h08);
    wr(A, 8'h00, 1'b0);
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_pass();
    t_force();
    t_store();
    t_ro();
    t_act();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule